// File: doc/BRIEF.md
# Multicycle 32-bit Integer Core (Seven-Instruction Subset)

This block is a small 32-bit processor core that runs each instruction as a short sequence of clock steps. One memory port serves both instruction fetch and data access. The core holds a 32-entry register file and a set of internal holding registers: an instruction register, two operand latches, an arithmetic result/target latch and a load-data latch. It executes seven instructions: register add, word load, word store, branch-if-equal, jump, jump-and-link and jump-through-register. Any other encoding is fetched, found to be unknown and dropped.

Every instruction begins with the same three steps. The first step presents PC on the memory port and adds 4 to PC. The second step captures the returned word, because the memory answers one clock after it sees the address. The third step reads both operand registers and, before the opcode is used, forms the branch target from the already-advanced PC. The later steps depend on the opcode. The port is meant for a memory with single-cycle registered reads. A store drives the write enable for one cycle.

Top module: `mc_core`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, mem_we is 0 and mem_addr is 0. The core starts by fetching the word at byte address 0.
- R2: In a fetch step, mem_addr shows PC and PC then advances by 4, so mem_addr shows PC+4 in the following step. The instruction word is taken from mem_rdata one clock after the fetch address was presented.
- R3: An instruction word with bits 31:26 = 0, bits 10:6 = 0 and bits 5:0 = 32 adds the registers named by bits 25:21 and 20:16, modulo 2^32. It writes the sum to the register named by bits 15:11 and takes 5 cycles.
- R4: Bits 31:26 = 35 loads the word at (register[25:21] + sign-extended bits 15:0) into the register named by bits 20:16. It takes 7 cycles, and negative offsets work.
- R5: Bits 31:26 = 43 writes register[20:16] to address (register[25:21] + sign-extended bits 15:0). mem_we is high for exactly one cycle, the fifth and last cycle of the instruction.
- R6: Bits 31:26 = 4 compares the registers named by bits 25:21 and 20:16. If they are equal, PC becomes the address of the next instruction plus (sign-extended bits 15:0) x 4. Otherwise execution falls through. Both cases take 4 cycles.
- R7: Bits 31:26 = 2 sets PC to {top 4 bits of next-instruction address, bits 25:0, 2'b00} and takes 4 cycles.
- R8: Bits 31:26 = 3 makes the same jump as R7 and writes the address of the jump-and-link instruction plus 4 into register 31.
- R9: Bits 31:26 = 0, bits 10:6 = 0 and bits 5:0 = 8 set PC to the register named by bits 25:21.
- R10: Register 0 always reads as 0, and writes to it are dropped.
- R11: Any other encoding (other opcodes, other function codes, or a nonzero bits 10:6 in an opcode-0 word) goes back to fetch after 3 cycles. It changes no register, no memory word, and nothing in PC beyond the +4.
- R12: Register-file and memory results land at fixed cycle offsets. In a straight-line run of load, load, add and store, consecutive store pulses are 24 cycles apart, and the first such store after reset pulses in cycle 24.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | 32 | Byte address for fetch, load or store |
| mem_wdata | output | 32 | Store data |
| mem_we | output | 1 | Store strobe, one cycle per store |
| mem_rdata | input | 32 | Read data, valid one clock after the address |

## Verification
The bench counts cycles from the end of reset, starting at 1 in the first fetch step, and logs the cycle of every store pulse. Instruction lengths are 3 cycles for unknown encodings, 4 for branches and jumps, 5 for add and store, and 7 for load. The expected store cycle is therefore the sum of the lengths of the instructions in front of it. The interval checks compare logged pulse cycles against these sums, for example 24 cycles per load/load/add/store group and 11 cycles across two unknown words. Data results are read from the bench memory only after the final marker store. Port-level fetch checks sample at the falling edge, one step after each register update.

// File: rtl/mc_pkg.sv
package mc_pkg;

    localparam int XLEN    = 32;
    localparam int REG_AW  = 5;
    localparam int NREG    = 1 << REG_AW;
    localparam int IMM_W   = 16;
    localparam int JIDX_W  = 26;
    localparam int LINK_RG = NREG - 1;

    localparam logic [5:0] OPC_SPECIAL = 6'd0;
    localparam logic [5:0] OPC_JUMP    = 6'd2;
    localparam logic [5:0] OPC_JLINK   = 6'd3;
    localparam logic [5:0] OPC_BREQ    = 6'd4;
    localparam logic [5:0] OPC_LOADW   = 6'd35;
    localparam logic [5:0] OPC_STOREW  = 6'd43;
    localparam logic [5:0] FN_SUM      = 6'd32;
    localparam logic [5:0] FN_JREG     = 6'd8;

    typedef enum logic [2:0] {
        ST_FETCH,
        ST_IRLD,
        ST_DECODE,
        ST_EXEC,
        ST_MEM,
        ST_MWAIT,
        ST_WB
    } step_e;

    typedef enum logic [2:0] {
        K_ADD,
        K_LW,
        K_SW,
        K_BEQ,
        K_J,
        K_JAL,
        K_JR,
        K_BAD
    } kind_e;

    typedef struct packed {
        step_e             step;
        logic [XLEN-1:0]   pc;
        logic [XLEN-1:0]   ir;
        logic [XLEN-1:0]   a;
        logic [XLEN-1:0]   b;
        logic [XLEN-1:0]   sum;
        logic [XLEN-1:0]   mdr;
    } core_s;

endpackage

// File: rtl/mc_decode.sv
module mc_decode
    import mc_pkg::*;
(
    input  logic [XLEN-1:0]   ir,
    output kind_e             kind,
    output logic [REG_AW-1:0] rs,
    output logic [REG_AW-1:0] rt,
    output logic [REG_AW-1:0] rd,
    output logic [XLEN-1:0]   imm_se,
    output logic [JIDX_W-1:0] jidx
);

    logic [5:0] opc;
    logic [5:0] fn;
    logic       shamt_zero;

    always_comb begin
        opc        = ir[31:26];
        fn         = ir[5:0];
        shamt_zero = (ir[10:6] == 5'd0);
        rs         = ir[25:21];
        rt         = ir[20:16];
        rd         = ir[15:11];
        imm_se     = {{(XLEN-IMM_W){ir[IMM_W-1]}}, ir[IMM_W-1:0]};
        jidx       = ir[JIDX_W-1:0];

        kind = K_BAD;
        case (opc)
            OPC_SPECIAL: begin
                if (shamt_zero && fn == FN_SUM)
                    kind = K_ADD;
                else if (shamt_zero && fn == FN_JREG)
                    kind = K_JR;
            end
            OPC_JUMP:   kind = K_J;
            OPC_JLINK:  kind = K_JAL;
            OPC_BREQ:   kind = K_BEQ;
            OPC_LOADW:  kind = K_LW;
            OPC_STOREW: kind = K_SW;
            default:    kind = K_BAD;
        endcase
    end

    // R11: a word with a nonzero shift field never decodes as add or jr
    always_comb begin
        a_r11_shamt_guard: assert (!((kind == K_ADD || kind == K_JR) && !shamt_zero));
    end

endmodule

// File: rtl/mc_regfile.sv
module mc_regfile #(
    parameter int W  = 32,
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] ra_a,
    input  logic [AW-1:0] ra_b,
    output logic [W-1:0]  rdat_a,
    output logic [W-1:0]  rdat_b,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_sel,
    input  logic [W-1:0]  wr_dat
);

    localparam int N = 1 << AW;

    logic [W-1:0] regs_q [N];
    logic [W-1:0] regs_d [N];

    always_comb begin
        for (int i = 0; i < N; i++) regs_d[i] = regs_q[i];
        if (wr_en && wr_sel != '0) regs_d[wr_sel] = wr_dat;
        regs_d[0] = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) regs_q[i] <= '0;
        end else begin
            for (int i = 0; i < N; i++) regs_q[i] <= regs_d[i];
        end
    end

    assign rdat_a = (ra_a == '0) ? '0 : regs_q[ra_a];
    assign rdat_b = (ra_b == '0) ? '0 : regs_q[ra_b];

    // R3/R4: a write to a nonzero register is visible on the next cycle
    a_r3_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel != '0) |=> (regs_q[$past(wr_sel)] == $past(wr_dat)));

endmodule

// File: rtl/mc_core.sv
module mc_core
    import mc_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    output logic [XLEN-1:0] mem_addr,
    output logic [XLEN-1:0] mem_wdata,
    output logic            mem_we,
    input  logic [XLEN-1:0] mem_rdata
);

    core_s q, d;

    kind_e             kind;
    logic [REG_AW-1:0] rs, rt, rd;
    logic [XLEN-1:0]   imm_se;
    logic [JIDX_W-1:0] jidx;

    logic [XLEN-1:0]   rdat_a, rdat_b;
    logic              rf_we;
    logic [REG_AW-1:0] rf_wa;
    logic [XLEN-1:0]   rf_wd;

    mc_decode u_dec (
        .ir     (q.ir),
        .kind   (kind),
        .rs     (rs),
        .rt     (rt),
        .rd     (rd),
        .imm_se (imm_se),
        .jidx   (jidx)
    );

    mc_regfile #(
        .W  (XLEN),
        .AW (REG_AW)
    ) u_rf (
        .clk    (clk),
        .rst_n  (rst_n),
        .ra_a   (rs),
        .ra_b   (rt),
        .rdat_a (rdat_a),
        .rdat_b (rdat_b),
        .wr_en  (rf_we),
        .wr_sel (rf_wa),
        .wr_dat (rf_wd)
    );

    always_comb begin
        d         = q;
        mem_addr  = q.pc;
        mem_wdata = q.b;
        mem_we    = 1'b0;
        rf_we     = 1'b0;
        rf_wa     = '0;
        rf_wd     = '0;

        case (q.step)
            ST_FETCH: begin
                d.pc   = q.pc + XLEN'(4);
                d.step = ST_IRLD;
            end
            ST_IRLD: begin
                d.ir   = mem_rdata;
                d.step = ST_DECODE;
            end
            ST_DECODE: begin
                d.a    = rdat_a;
                d.b    = rdat_b;
                d.sum  = q.pc + (imm_se << 2);
                d.step = (kind == K_BAD) ? ST_FETCH : ST_EXEC;
            end
            ST_EXEC: begin
                d.step = ST_FETCH;
                case (kind)
                    K_ADD: begin
                        d.sum  = q.a + q.b;
                        d.step = ST_WB;
                    end
                    K_LW, K_SW: begin
                        d.sum  = q.a + imm_se;
                        d.step = ST_MEM;
                    end
                    K_BEQ: begin
                        if ((q.a - q.b) == '0) d.pc = q.sum;
                    end
                    K_J: begin
                        d.pc = {q.pc[XLEN-1:JIDX_W+2], jidx, 2'b00};
                    end
                    K_JAL: begin
                        d.pc  = {q.pc[XLEN-1:JIDX_W+2], jidx, 2'b00};
                        rf_we = 1'b1;
                        rf_wa = REG_AW'(LINK_RG);
                        rf_wd = q.pc;
                    end
                    K_JR: begin
                        d.pc = q.a;
                    end
                    default: d.step = ST_FETCH;
                endcase
            end
            ST_MEM: begin
                mem_addr = q.sum;
                if (kind == K_SW) begin
                    mem_we = 1'b1;
                    d.step = ST_FETCH;
                end else begin
                    d.step = ST_MWAIT;
                end
            end
            ST_MWAIT: begin
                mem_addr = q.sum;
                d.mdr    = mem_rdata;
                d.step   = ST_WB;
            end
            ST_WB: begin
                rf_we  = 1'b1;
                rf_wa  = (kind == K_LW) ? rt : rd;
                rf_wd  = (kind == K_LW) ? q.mdr : q.sum;
                d.step = ST_FETCH;
            end
            default: d.step = ST_FETCH;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R2: a fetch step advances PC by one word
    a_r2_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
        (q.step == ST_FETCH) |=> (q.pc == $past(q.pc) + XLEN'(4)));

    // R2: the instruction register takes the word returned after the fetch
    a_r2_ir_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (q.step == ST_IRLD) |=> (q.ir == $past(mem_rdata)));

    // R5: store strobe lasts one cycle
    a_r5_we_single: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);

    // R5: store strobe only follows an execute step
    a_r5_we_after_exec: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> ($past(q.step) == ST_EXEC));

    // R6: an unequal compare leaves PC alone
    a_r6_beq_fallthru: assert property (@(posedge clk) disable iff (!rst_n)
        (q.step == ST_EXEC && kind == K_BEQ && q.a != q.b) |=> $stable(q.pc));

    // R10: operand latch from register 0 is zero
    a_r10_zero_operand: assert property (@(posedge clk) disable iff (!rst_n)
        (q.step == ST_DECODE && rs == '0) |=> (q.a == '0));

    // R11: an unknown word returns to fetch with PC unchanged
    a_r11_bad_returns: assert property (@(posedge clk) disable iff (!rst_n)
        (q.step == ST_DECODE && kind == K_BAD) |=> (q.step == ST_FETCH && $stable(q.pc)));

endmodule

// File: tb/mc_core_bench.sv
module mc_core_bench;

    localparam int CLK_PERIOD = 10;
    localparam int MEM_WORDS  = 1024;
    localparam int WATCHDOG   = 20000;
    localparam int NVEC       = 16;

    localparam logic [31:0] DATA_A  = 32'h800;
    localparam logic [31:0] MARK_A  = 32'h900;
    localparam logic [31:0] BASE_A  = 32'h904;
    localparam logic [31:0] NEG_SRC = 32'h930;
    localparam logic [31:0] NEG_DST = 32'h93C;
    localparam logic [31:0] RES_A   = 32'hC00;
    localparam logic [31:0] Z0_A    = 32'hC40;
    localparam logic [31:0] Z1_A    = 32'hC44;
    localparam logic [31:0] SKIP_A  = 32'hC48;
    localparam logic [31:0] NT_A    = 32'hC4C;
    localparam logic [31:0] JSKIP_A = 32'hC50;
    localparam logic [31:0] RA_A    = 32'hC54;
    localparam logic [31:0] RET_A   = 32'hC58;
    localparam logic [31:0] UND_A   = 32'hC5C;
    localparam logic [31:0] UND0_A  = 32'hC68;
    localparam logic [31:0] DONE_A  = 32'hC64;
    localparam logic [31:0] MARK    = 32'hA5A5_0001;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        mem_we;

    logic [31:0] img [MEM_WORDS];
    logic [31:0] mem [MEM_WORDS];
    logic [31:0] exp_res [NVEC];
    int          wp;
    logic [31:0] ra_exp;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    int nwe = 0;
    int we_cyc [64];
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mc_core u_mc_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_we    (mem_we),
        .mem_rdata (mem_rdata)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < MEM_WORDS; i++) mem[i] <= img[i];
        end else if (mem_we) begin
            mem[mem_addr[11:2]] <= mem_wdata;
        end
        mem_rdata <= mem[mem_addr[11:2]];
    end

    always @(negedge clk) begin
        if (rst_n) begin
            cyc = cyc + 1;
            if (mem_we) begin
                if (nwe < 64) we_cyc[nwe] = cyc;
                nwe = nwe + 1;
                if (mem_addr == DONE_A) done = 1'b1;
            end
        end
    end

    function automatic logic [31:0] i_w(logic [31:0] op, logic [31:0] rs,
                                        logic [31:0] rt, logic [31:0] imm);
        return {op[5:0], rs[4:0], rt[4:0], imm[15:0]};
    endfunction

    function automatic logic [31:0] r_w(logic [31:0] rs, logic [31:0] rt,
                                        logic [31:0] rd, logic [31:0] fn);
        return {6'd0, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn[5:0]};
    endfunction

    function automatic logic [31:0] j_w(logic [31:0] op, logic [31:0] widx);
        return {op[5:0], widx[25:0]};
    endfunction

    task automatic put(input logic [31:0] w);
        img[wp] = w;
        wp = wp + 1;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk = n_chk + 1;
        if (act !== exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic build;
        logic [31:0] a, b;
        int p;
        for (int i = 0; i < MEM_WORDS; i++) img[i] = '0;
        wp = 0;
        // R3/R4/R5/R12: sweep of operands and register numbers
        for (int k = 0; k < NVEC; k++) begin
            a = 32'h7FFF_FFFF - 32'(k) * 32'h1357_9BDF;
            b = 32'(k) * 32'h0F0F_0F0F + 32'd1;
            if (k == 1) a = 32'hFFFF_FFFF;
            img[(DATA_A >> 2) + 2*k]     = a;
            img[(DATA_A >> 2) + 2*k + 1] = b;
            exp_res[k] = a + b;
            put(i_w(35, 0, 1 + k % 3, DATA_A + 8*k));
            put(i_w(35, 0, 10 + k % 4, DATA_A + 8*k + 4));
            put(r_w(1 + k % 3, 10 + k % 4, 16 + k % 8, 32));
            put(i_w(43, 0, 16 + k % 8, RES_A + 4*k));
        end
        img[MARK_A >> 2]  = MARK;
        img[BASE_A >> 2]  = 32'h940;
        img[NEG_SRC >> 2] = 32'h1234_5678;
        // R10
        put(i_w(35, 0, 0, MARK_A));
        put(i_w(43, 0, 0, Z0_A));
        put(r_w(1, 10, 0, 32));
        put(i_w(43, 0, 0, Z1_A));
        // R4/R5 negative offsets
        put(i_w(35, 0, 5, BASE_A));
        put(i_w(35, 5, 6, 32'hFFF0));
        put(i_w(43, 5, 6, 32'hFFFC));
        // R6
        put(i_w(35, 0, 7, MARK_A));
        put(i_w(4, 7, 7, 1));
        put(i_w(43, 0, 7, SKIP_A));
        put(i_w(4, 7, 0, 1));
        put(i_w(43, 0, 7, NT_A));
        // R7
        p = wp;
        put(j_w(2, 32'(p + 2)));
        put(i_w(43, 0, 7, JSKIP_A));
        // R8/R9
        p = wp;
        put(j_w(3, 32'(p + 3)));
        put(i_w(43, 0, 7, RET_A));
        put(j_w(2, 32'(p + 5)));
        put(i_w(43, 0, 31, RA_A));
        put(r_w(31, 0, 0, 8));
        ra_exp = 32'((p + 1) * 4);
        // R11
        put(i_w(43, 0, 7, UND0_A));
        put(32'hFC00_0000);
        put(r_w(1, 10, 7, 42));
        put(i_w(43, 0, 7, UND_A));
        put(i_w(43, 0, 7, DONE_A));
        p = wp;
        put(j_w(2, 32'(p)));
    endtask

    initial begin
        build();
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 we in reset", {31'd0, mem_we}, 32'd0);
        chk("R1 addr in reset", mem_addr, 32'd0);
        rst_n = 1'b1;
        chk("R1 first fetch addr", mem_addr, 32'd0);
        @(negedge clk);
        chk("R2 pc advanced", mem_addr, 32'd4);

        while (!done && cyc < WATCHDOG) @(negedge clk);
        if (!done) begin
            n_chk = n_chk + 1;
            n_fail = n_fail + 1;
            $display("FAIL watchdog: actual %0d cycles expected done marker", cyc);
        end
        repeat (3) @(negedge clk);

        chk("R12 first store cycle", 32'(we_cyc[0]), 32'd24);
        for (int k = 1; k < NVEC; k++)
            chk("R12 load/load/add/store interval", 32'(we_cyc[k] - we_cyc[k-1]), 32'd24);
        for (int k = 0; k < NVEC; k++)
            chk("R3 add result", mem[(RES_A >> 2) + k], exp_res[k]);
        chk("R10 load into r0", mem[Z0_A >> 2], 32'd0);
        chk("R10 add into r0", mem[Z1_A >> 2], 32'd0);
        chk("R4 lw timing via store interval", 32'(we_cyc[16] - we_cyc[15]), 32'd12);
        chk("R4 R5 negative offset", mem[NEG_DST >> 2], 32'h1234_5678);
        chk("R6 taken skips store", mem[SKIP_A >> 2], 32'd0);
        chk("R6 untaken falls through", mem[NT_A >> 2], MARK);
        chk("R6 beq timing", 32'(we_cyc[19] - we_cyc[18]), 32'd20);
        chk("R7 jump skips store", mem[JSKIP_A >> 2], 32'd0);
        chk("R7 R8 jump timing", 32'(we_cyc[20] - we_cyc[19]), 32'd13);
        chk("R8 link value", mem[RA_A >> 2], ra_exp);
        chk("R9 return lands", mem[RET_A >> 2], MARK);
        chk("R11 unknown words timing", 32'(we_cyc[23] - we_cyc[22]), 32'd11);
        chk("R11 register untouched", mem[UND_A >> 2], MARK);
        chk("R5 store count", 32'(nwe), 32'd25);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule